// File: doc/BRIEF.md
# Two-Class Priority Interrupt Arbiter

This block sits between the interrupt capture logic of a controller and the processor. Each cycle it receives flat vectors for every interrupt line: pending, masked, and fast-class select, plus a priority field. For each of the two classes it picks the most urgent eligible line. The fast class drives the fast request pin and the normal class drives the normal request pin. Lower priority values are more urgent. When priorities are equal, the line with the higher index wins.

Each class has a one-shot arming handshake. An armed class fires on the first clock edge where it has an eligible line and the global enable is on. At that edge it raises its request and captures the winning line index. Both then stay frozen until software sends a one-cycle re-arm strobe for that class. On the strobe edge the class is evaluated again. If a line is still eligible, the request stays high with a freshly captured index. Otherwise the request drops and the class waits armed.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A line is eligible for a class when it is pending, not masked, and its fast-select bit matches the class: bit value 1 selects the fast class and bit value 0 selects the normal class.
- R2: Among the eligible lines of a class, the line with the smallest priority value wins. Value 0 is the most urgent.
- R3: When several eligible lines share the winning priority value, the line with the highest index wins. This also holds across 32-line group boundaries.
- R4: The captured code is the binary line index, from 0 to NUM_LINES-1. When no line is eligible, the internal winner is 0.
- R5: An armed class raises its request at the first rising edge where it has an eligible line and the global enable is high. With the enable low, or with no eligible line, a low request stays low.
- R6: Once a request is high and no re-arm strobe for that class arrives, the request stays high and its code is unchanged, whatever the inputs do.
- R7: After reset both requests are low, both codes are 0, and both classes are armed.
- R8: On a re-arm strobe edge, if the class has an eligible line and the enable is high, the request is high after that edge with the new winner's code. Otherwise the request goes low and the class becomes armed.
- R9: The two classes are independent. Both may fire at the same edge, and a strobe for one class leaves the other class's request and code untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_LINES | Pending flag per line |
| mask_i | input | NUM_LINES | Mask flag per line (1 = blocked) |
| fast_sel_i | input | NUM_LINES | Class select per line (1 = fast, 0 = normal) |
| prio_i | input | NUM_LINES*PRIO_W | Priority per line; line i occupies bits i*PRIO_W upward |
| glob_en_i | input | 1 | Global enable for firing |
| rearm_fast_i | input | 1 | One-cycle re-arm strobe, fast class |
| rearm_norm_i | input | 1 | One-cycle re-arm strobe, normal class |
| fast_req_o | output | 1 | Fast-class request |
| norm_req_o | output | 1 | Normal-class request |
| fast_code_o | output | CODE_W | Captured fast-class winner index |
| norm_code_o | output | CODE_W | Captured normal-class winner index |

## Verification
The vector table places two lines per case so that each case isolates one rule of the selection:
- equal priorities at low and high indices, including a pair that straddles a 32-line group, show which way ties resolve;
- a less urgent line at the higher index shows that priority is compared before index;
- a more urgent masked line, or one of the other class, shows what is excluded from eligibility;
- cases that load both classes at once show that they are independent.

Directed sequences then change inputs while a request is frozen, strobe re-arm with and without a remaining eligible line, hold the global enable low, and check the reset state.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    CLS_NORM = 1'b0,
    CLS_FAST = 1'b1
  } cls_e;

  localparam int NUM_CLASSES = 2;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NUM_LINES = 96,
  parameter int PRIO_W    = 6,
  parameter int CODE_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        elig,
  input  logic [NUM_LINES*PRIO_W-1:0] prio,
  output logic                        any,
  output logic [CODE_W-1:0]           win
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with <= lets the later (higher) index take ties.
  always_comb begin
    best = '1;
    win  = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (elig[i] && (prio[i*PRIO_W +: PRIO_W] <= best)) begin
        best = prio[i*PRIO_W +: PRIO_W];
        win  = CODE_W'(i);
      end
    end
    any = |elig;
  end

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !any |-> (win == '0)); // R4
  AST_WIN_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    any |-> elig[win]); // R1
endmodule

// File: rtl/arb_slot.sv
module arb_slot #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              any,
  input  logic [CODE_W-1:0] win,
  input  logic              rearm,
  output logic              req,
  output logic [CODE_W-1:0] code
);
  logic armed;
  logic fire_ok;

  assign fire_ok = any && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      req   <= 1'b0;
      code  <= '0;
    end else if (rearm) begin
      if (fire_ok) begin
        req   <= 1'b1;
        code  <= win;
        armed <= 1'b0;
      end else begin
        req   <= 1'b0;
        armed <= 1'b1;
      end
    end else if (armed && fire_ok) begin
      req   <= 1'b1;
      code  <= win;
      armed <= 1'b0;
    end
  end

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (req && !rearm) |=> (req && $stable(code))); // R6
  AST_NO_FIRE_GATED: assert property (@(posedge clk) disable iff (rst)
    (!req && !fire_ok) |=> !req); // R5
  AST_REARM_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rearm && !fire_ok) |=> !req); // R8
  AST_REARM_REFIRES: assert property (@(posedge clk) disable iff (rst)
    (rearm && fire_ok) |=> req); // R8
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
  parameter int NUM_LINES = 96,
  parameter int PRIO_W    = 6,
  parameter int CODE_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        pend_i,
  input  logic [NUM_LINES-1:0]        mask_i,
  input  logic [NUM_LINES-1:0]        fast_sel_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  input  logic                        glob_en_i,
  input  logic                        rearm_fast_i,
  input  logic                        rearm_norm_i,
  output logic                        fast_req_o,
  output logic                        norm_req_o,
  output logic [CODE_W-1:0]           fast_code_o,
  output logic [CODE_W-1:0]           norm_code_o
);
  import arb_pkg::*;

  logic [NUM_LINES-1:0] elig  [NUM_CLASSES];
  logic                 any   [NUM_CLASSES];
  logic [CODE_W-1:0]    win   [NUM_CLASSES];
  logic                 rearm [NUM_CLASSES];
  logic                 req   [NUM_CLASSES];
  logic [CODE_W-1:0]    code  [NUM_CLASSES];

  assign rearm[CLS_NORM] = rearm_norm_i;
  assign rearm[CLS_FAST] = rearm_fast_i;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    if (c == int'(CLS_FAST)) begin : g_fast
      assign elig[c] = pend_i & ~mask_i & fast_sel_i;
    end else begin : g_norm
      assign elig[c] = pend_i & ~mask_i & ~fast_sel_i;
    end

    prio_pick #(
      .NUM_LINES(NUM_LINES),
      .PRIO_W   (PRIO_W),
      .CODE_W   (CODE_W)
    ) u_pick (
      .clk (clk),
      .rst (rst),
      .elig(elig[c]),
      .prio(prio_i),
      .any (any[c]),
      .win (win[c])
    );

    arb_slot #(
      .CODE_W(CODE_W)
    ) u_slot (
      .clk  (clk),
      .rst  (rst),
      .en   (glob_en_i),
      .any  (any[c]),
      .win  (win[c]),
      .rearm(rearm[c]),
      .req  (req[c]),
      .code (code[c])
    );
  end

  assign fast_req_o  = req[CLS_FAST];
  assign norm_req_o  = req[CLS_NORM];
  assign fast_code_o = code[CLS_FAST];
  assign norm_code_o = code[CLS_NORM];

  AST_FAST_KEEPS_ON_NORM_REARM: assert property (@(posedge clk) disable iff (rst)
    (fast_req_o && !rearm_fast_i && rearm_norm_i) |=> (fast_req_o && $stable(fast_code_o))); // R9
endmodule

// File: tb/sim_prio_irq_arbiter.sv
`timescale 1ns/1ps
module sim_prio_irq_arbiter;
  localparam int N  = 96;
  localparam int PW = 6;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0]    pend, mask, fsel;
  logic [N*PW-1:0] prio;
  logic            en, rf, rn;
  logic            freq, nreq;
  logic [CW-1:0]   fcode, ncode;

  always #2 clk = ~clk;

  prio_irq_arbiter #(.NUM_LINES(N), .PRIO_W(PW)) u0 (
    .clk(clk), .rst(rst), .pend_i(pend), .mask_i(mask), .fast_sel_i(fsel),
    .prio_i(prio), .glob_en_i(en), .rearm_fast_i(rf), .rearm_norm_i(rn),
    .fast_req_o(freq), .norm_req_o(nreq), .fast_code_o(fcode), .norm_code_o(ncode)
  );

  typedef struct packed {
    logic [6:0] al; logic [5:0] ap; logic af;
    logic [6:0] bl; logic [5:0] bp; logic bf; logic bm;
    logic efr; logic [6:0] efc; logic enr; logic [6:0] enc;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{7'd5,  6'd3,  1'b0, 7'd5,  6'd3,  1'b0, 1'b0, 1'b0, 7'd0,  1'b1, 7'd5},  // R1
    '{7'd5,  6'd3,  1'b0, 7'd70, 6'd3,  1'b0, 1'b0, 1'b0, 7'd0,  1'b1, 7'd70}, // R3
    '{7'd70, 6'd4,  1'b0, 7'd5,  6'd2,  1'b0, 1'b0, 1'b0, 7'd0,  1'b1, 7'd5},  // R2
    '{7'd10, 6'd0,  1'b1, 7'd20, 6'd0,  1'b0, 1'b0, 1'b1, 7'd10, 1'b1, 7'd20}, // R9
    '{7'd95, 6'd63, 1'b1, 7'd1,  6'd62, 1'b1, 1'b0, 1'b1, 7'd1,  1'b0, 7'd0},  // R2
    '{7'd40, 6'd5,  1'b0, 7'd50, 6'd1,  1'b0, 1'b1, 1'b0, 7'd0,  1'b1, 7'd40}, // R1
    '{7'd33, 6'd9,  1'b0, 7'd34, 6'd1,  1'b1, 1'b0, 1'b1, 7'd34, 1'b1, 7'd33}, // R1
    '{7'd64, 6'd7,  1'b0, 7'd63, 6'd7,  1'b0, 1'b0, 1'b0, 7'd0,  1'b1, 7'd64}, // R3
    '{7'd31, 6'd0,  1'b1, 7'd90, 6'd0,  1'b1, 1'b0, 1'b1, 7'd90, 1'b0, 7'd0}   // R3
  };

  int vecs = 0;
  int errs = 0;
  logic [CW-1:0] mf = '0;
  logic [CW-1:0] mn = '0;

  task automatic chk(input string r, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clear_in();
    pend = '0; mask = '0; fsel = '0; prio = '0;
  endtask

  task automatic put(input int l, input int p, input logic f, input logic m);
    pend[l] = 1'b1;
    mask[l] = m;
    fsel[l] = f;
    prio[l*PW +: PW] = PW'(p);
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b1; rf = 1'b0; rn = 1'b0;
    clear_in();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    chk("R7 fast req", int'(freq), 0);
    chk("R7 norm req", int'(nreq), 0);
    chk("R7 R4 fast code", int'(fcode), 0);
    chk("R7 R4 norm code", int'(ncode), 0);

    foreach (TBL[k]) begin
      clear_in();
      rf = 1'b1; rn = 1'b1;
      @(negedge clk);
      rf = 1'b0; rn = 1'b0;
      chk("R8 fast low after empty rearm", int'(freq), 0);
      put(int'(TBL[k].al), int'(TBL[k].ap), TBL[k].af, 1'b0);
      put(int'(TBL[k].bl), int'(TBL[k].bp), TBL[k].bf, TBL[k].bm);
      @(negedge clk);
      if (TBL[k].efr) mf = TBL[k].efc;
      if (TBL[k].enr) mn = TBL[k].enc;
      chk("R5 fast req", int'(freq), int'(TBL[k].efr));
      chk("R5 norm req", int'(nreq), int'(TBL[k].enr));
      chk("R2 R3 R4 fast code", int'(fcode), int'(mf));
      chk("R2 R3 R4 norm code", int'(ncode), int'(mn));
    end

    // R6: fast is high with 90; better inputs must not disturb it
    clear_in();
    put(3, 0, 1'b1, 1'b0);
    put(7, 4, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6 fast held", int'(freq), 1);
    chk("R6 fast code frozen", int'(fcode), 90);
    chk("R5 norm fires", int'(ncode), 7);
    @(negedge clk);
    chk("R6 fast code still frozen", int'(fcode), 90);

    // R8: rearm with line 3 still eligible -> fresh code, R9 norm untouched
    rf = 1'b1;
    @(negedge clk);
    rf = 1'b0;
    chk("R8 fast refire", int'(freq), 1);
    chk("R8 fast fresh code", int'(fcode), 3);
    chk("R9 norm req kept", int'(nreq), 1);
    chk("R9 norm code kept", int'(ncode), 7);

    // R8: rearm with nothing eligible
    clear_in();
    rf = 1'b1;
    @(negedge clk);
    rf = 1'b0;
    chk("R8 fast drops", int'(freq), 0);
    chk("R8 fast code kept", int'(fcode), 3);

    // R5: global enable low blocks firing
    en = 1'b0; rn = 1'b1;
    put(12, 1, 1'b0, 1'b0);
    @(negedge clk);
    rn = 1'b0;
    chk("R5 norm blocked by enable", int'(nreq), 0);
    @(negedge clk);
    chk("R5 norm still blocked", int'(nreq), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R5 norm fires on enable", int'(nreq), 1);
    chk("R5 norm code", int'(ncode), 12);

    // R1: masked line is not eligible
    clear_in();
    rn = 1'b1; rf = 1'b1;
    @(negedge clk);
    rn = 1'b0; rf = 1'b0;
    put(8, 0, 1'b0, 1'b1);
    put(9, 0, 1'b1, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R1 masked norm", int'(nreq), 0);
    chk("R1 masked fast", int'(freq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule